// File: doc/BRIEF.md
# Accumulator Add Executor

This unit carries out the register-to-accumulator add group of an 8-bit processor core. It takes an opcode byte, and for one opcode an immediate byte, with a single-cycle start strobe. It then takes its operand from one of three places: a general register, read through a combinational register-file read port; a memory byte whose 16-bit address is the H:L register pair; or the immediate byte. The operand is added to the accumulator value presented on `a_i`.

When the instruction completes, `done_o` pulses for one cycle. In that cycle the new accumulator value and the four flags are valid. The surrounding register file writes both on the clock edge that ends the `done_o` cycle, so `done_o` is the write enable for A and for the flags.

The unit reports any opcode outside the group on `illegal_o` and starts nothing for it. It also reports the immediate form when no immediate byte is supplied. A start that arrives while an instruction is in progress is ignored.

Top module: `acc_add_exec`

## Requirements
- R1: Opcodes 0x80 to 0x85 add register index opcode[2:0] (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, driven on `rf_sel_o`) to A. `done_o` is high in the 4th cycle, counting the start cycle as the first.
- R2: Opcode 0x86 reads H (index 4) and then L (index 5) through `rf_sel_o`. It issues exactly one memory read with `mem_re_o` at address {H,L}. It adds the byte returned in the following cycle to A, and `done_o` is high in the 8th cycle.
- R3: Opcode 0xC6 with `imm_valid_i` high adds `imm_i` to A, with `done_o` in the 4th cycle. With `imm_valid_i` low it is treated as illegal, as in R8.
- R4: Flag bit 2 (N) is 0 whenever `done_o` is high.
- R5: Flag bit 1 (H) is 1 exactly when the low nibbles of A and the operand sum to more than 0xF.
- R6: Flag bit 0 (C) is 1 exactly when A plus the operand exceeds 0xFF, and `a_wdata_o` holds the low 8 bits of the sum.
- R7: Flag bit 3 (Z) is 1 exactly when `a_wdata_o` is zero.
- R8: A start with an opcode outside the group raises `illegal_o` for exactly the following cycle. It produces no `done_o` and no `mem_re_o`.
- R9: `done_o` is a single-cycle pulse, once per accepted instruction.
- R10: `mem_addr_o` is unchanged in the cycle after `mem_re_o`, when the read data is captured.
- R11: A start while an instruction is in progress is ignored. It raises no `illegal_o`, and it does not change the timing or the result of the instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| opcode_i | input | 8 | Opcode byte, sampled with start |
| imm_i | input | 8 | Immediate byte, sampled with start |
| imm_valid_i | input | 1 | Immediate byte present |
| a_i | input | 8 | Current accumulator value |
| rf_sel_o | output | 3 | Register-file read index |
| rf_data_i | input | 8 | Register-file read data, combinational |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address {H,L} |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after the strobe |
| a_wdata_o | output | 8 | New accumulator value, valid with done |
| flags_o | output | 4 | {Z,N,H,C}, valid with done |
| done_o | output | 1 | Completion strobe and write enable for A and flags |
| illegal_o | output | 1 | Unknown or malformed opcode |

## Verification
The case hardest to reach from the ports is a start that arrives in the middle of the memory-indirect sequence, after H has been read but before the memory byte returns. The bench drives an illegal opcode and then a register-add opcode at two chosen cycles inside an 0x86 instruction. It then checks that `illegal_o` stays low and that `done_o` still falls in the 8th cycle with the sum for the memory operand. The memory model returns the chosen byte only for the expected {H,L} address and returns its complement otherwise, so a wrong address or wrong register order shows up in the sum.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;
  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/acc_add_decode.sv
module acc_add_decode
  import acc_add_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned RIW  = 3,
  parameter int unsigned NREG = 6,
  parameter logic [DW-1:0] REG_BASE = 8'h80,
  parameter logic [DW-1:0] MEM_OP   = 8'h86,
  parameter logic [DW-1:0] IMM_OP   = 8'hC6
) (
  input  logic [DW-1:0]  opcode_i,
  input  logic           imm_valid_i,
  output src_e           src_o,
  output logic [RIW-1:0] reg_idx_o,
  output logic           legal_o
);
  logic [NREG-1:0] reg_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg_hit
    assign reg_hit[g] = (opcode_i == DW'(REG_BASE + g));
  end

  always_comb begin
    if (|reg_hit)                              src_o = SRC_REG;
    else if (opcode_i == MEM_OP)               src_o = SRC_MEM;
    else if (opcode_i == IMM_OP && imm_valid_i) src_o = SRC_IMM;
    else                                       src_o = SRC_NONE;
  end

  assign reg_idx_o = opcode_i[RIW-1:0];
  assign legal_o   = (src_o != SRC_NONE);
endmodule

// File: rtl/acc_add_alu.sv
module acc_add_alu
  import acc_add_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  output logic [DW-1:0]     sum_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned HW = DW / 2;

  logic [HW:0] low_sum;
  logic [DW:0] full_sum;

  always_comb begin
    low_sum  = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]};
    full_sum = {1'b0, a_i} + {1'b0, b_i};
    sum_o    = full_sum[DW-1:0];
    flags_o          = '0;
    flags_o[FLAG_Z]  = (full_sum[DW-1:0] == '0);
    flags_o[FLAG_N]  = 1'b0;
    flags_o[FLAG_H]  = low_sum[HW];
    flags_o[FLAG_C]  = full_sum[DW];
  end
endmodule

// File: rtl/acc_add_seq.sv
module acc_add_seq
  import acc_add_pkg::*;
#(
  parameter int unsigned REG_LAT = 4,
  parameter int unsigned MEM_LAT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  src_e src_i,
  output logic busy_o,
  output logic cap_h_o,
  output logic cap_l_o,
  output logic cap_opnd_o,
  output logic mem_re_o,
  output logic cap_mem_o,
  output logic calc_o,
  output logic done_o
);
  localparam int unsigned PHW = $clog2(MEM_LAT + 1);
  localparam logic [PHW-1:0] REG_LAST = PHW'(REG_LAT - 1);
  localparam logic [PHW-1:0] MEM_LAST = PHW'(MEM_LAT - 1);
  localparam logic [PHW-1:0] REG_CALC = PHW'(REG_LAT - 2);
  localparam logic [PHW-1:0] MEM_CALC = PHW'(MEM_LAT - 2);
  localparam logic [PHW-1:0] PH_H     = PHW'(1);
  localparam logic [PHW-1:0] PH_L     = PHW'(2);
  localparam logic [PHW-1:0] PH_RE    = PHW'(3);
  localparam logic [PHW-1:0] PH_CAP   = PHW'(4);

  logic           busy_q;
  logic [PHW-1:0] ph_q;
  src_e           src_q;
  logic [PHW-1:0] last_ph;
  logic           is_mem;
  logic           is_reg;

  assign last_ph = (src_q == SRC_MEM) ? MEM_LAST : REG_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      src_q  <= SRC_NONE;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      ph_q   <= PHW'(1);
      src_q  <= src_i;
    end else if (busy_q) begin
      if (ph_q == last_ph) begin
        busy_q <= 1'b0;
        ph_q   <= '0;
      end else begin
        ph_q <= ph_q + PHW'(1);
      end
    end
  end

  assign is_mem     = busy_q && (src_q == SRC_MEM);
  assign is_reg     = busy_q && (src_q == SRC_REG);
  assign busy_o     = busy_q;
  assign cap_h_o    = is_mem && (ph_q == PH_H);
  assign cap_l_o    = is_mem && (ph_q == PH_L);
  assign mem_re_o   = is_mem && (ph_q == PH_RE);
  assign cap_mem_o  = is_mem && (ph_q == PH_CAP);
  assign cap_opnd_o = is_reg && (ph_q == PH_H);
  assign calc_o     = busy_q && (ph_q == (is_mem ? MEM_CALC : REG_CALC));
  assign done_o     = busy_q && (ph_q == last_ph);

  // R2
  mem_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mem_o |-> $past(mem_re_o));

  // R2
  h_before_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_l_o |-> $past(cap_h_o));

  // R9
  done_after_calc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !calc_o);
endmodule

// File: rtl/acc_add_exec.sv
module acc_add_exec
  import acc_add_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned RIW     = 3,
  parameter int unsigned REG_LAT = 4,
  parameter int unsigned MEM_LAT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     opcode_i,
  input  logic [DW-1:0]     imm_i,
  input  logic              imm_valid_i,
  input  logic [DW-1:0]     a_i,
  output logic [RIW-1:0]    rf_sel_o,
  input  logic [DW-1:0]     rf_data_i,
  output logic              mem_re_o,
  output logic [2*DW-1:0]   mem_addr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [DW-1:0]     a_wdata_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam logic [RIW-1:0] H_IDX = RIW'(4);
  localparam logic [RIW-1:0] L_IDX = RIW'(5);

  src_e           dec_src;
  logic [RIW-1:0] dec_idx;
  logic           dec_legal;
  logic           busy;
  logic           launch;
  logic           cap_h, cap_l, cap_opnd, cap_mem, calc;

  logic [RIW-1:0]    reg_idx_q;
  logic [DW-1:0]     h_q, l_q, opnd_q, sum_q;
  logic [FLAG_W-1:0] flags_q;
  logic              illegal_q;
  logic [DW-1:0]     alu_sum;
  logic [FLAG_W-1:0] alu_flags;

  acc_add_decode #(.DW(DW), .RIW(RIW)) u_dec (
    .opcode_i    (opcode_i),
    .imm_valid_i (imm_valid_i),
    .src_o       (dec_src),
    .reg_idx_o   (dec_idx),
    .legal_o     (dec_legal)
  );

  assign launch = start_i && !busy && dec_legal;

  acc_add_seq #(.REG_LAT(REG_LAT), .MEM_LAT(MEM_LAT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .src_i      (dec_src),
    .busy_o     (busy),
    .cap_h_o    (cap_h),
    .cap_l_o    (cap_l),
    .cap_opnd_o (cap_opnd),
    .mem_re_o   (mem_re_o),
    .cap_mem_o  (cap_mem),
    .calc_o     (calc),
    .done_o     (done_o)
  );

  acc_add_alu #(.DW(DW)) u_alu (
    .a_i     (a_i),
    .b_i     (opnd_q),
    .sum_o   (alu_sum),
    .flags_o (alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_idx_q <= '0;
      h_q       <= '0;
      l_q       <= '0;
      opnd_q    <= '0;
      sum_q     <= '0;
      flags_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= start_i && !busy && !dec_legal;
      if (launch) begin
        reg_idx_q <= dec_idx;
        if (dec_src == SRC_IMM) opnd_q <= imm_i;
      end
      if (cap_h)    h_q    <= rf_data_i;
      if (cap_l)    l_q    <= rf_data_i;
      if (cap_opnd) opnd_q <= rf_data_i;
      if (cap_mem)  opnd_q <= mem_rdata_i;
      if (calc) begin
        sum_q   <= alu_sum;
        flags_q <= alu_flags;
      end
    end
  end

  always_comb begin
    if (cap_h)      rf_sel_o = H_IDX;
    else if (cap_l) rf_sel_o = L_IDX;
    else            rf_sel_o = reg_idx_q;
  end

  assign mem_addr_o = {h_q, l_q};
  assign a_wdata_o  = sum_q;
  assign flags_o    = flags_q;
  assign illegal_o  = illegal_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  n_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !flags_o[FLAG_N]);

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FLAG_Z] == (a_wdata_o == '0)));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!done_o && !mem_re_o && !busy));

  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> $stable(mem_addr_o));

  // R11
  busy_no_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> !illegal_o);
endmodule

// File: tb/sim_acc_add_exec.sv
module sim_acc_add_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  imm = 8'h00;
  logic        immv = 1'b0;
  logic [7:0]  a_val = 8'h00;
  logic [2:0]  rf_sel;
  logic [7:0]  rf_data;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  a_wdata;
  logic [3:0]  flags;
  logic        done;
  logic        illegal;

  logic [7:0]  regs [0:7];
  logic [15:0] mem_exp_addr = 16'h0000;
  logic [7:0]  mem_val = 8'h00;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  assign rf_data = regs[rf_sel];

  always @(posedge clk)
    if (mem_re) mem_rdata <= (mem_addr == mem_exp_addr) ? mem_val : ~mem_val;

  acc_add_exec u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .imm_i(imm), .imm_valid_i(immv), .a_i(a_val), .rf_sel_o(rf_sel),
    .rf_data_i(rf_data), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .a_wdata_o(a_wdata), .flags_o(flags),
    .done_o(done), .illegal_o(illegal)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Drives one instruction and watches a fixed window; lat=0 means illegal expected.
  task automatic run_op(input logic [7:0] op, input logic [7:0] im, input bit iv,
                        input int lat, input logic [7:0] b, input bit is_mem,
                        input string req);
    int dn = 0, ndone = 0, nmre = 0, nill = 0, ill_at = 0;
    logic [15:0] maddr = 16'h0;
    logic [7:0] wd = 8'h0;
    logic [3:0] fl = 4'h0;
    int s = int'(a_val) + int'(b);
    int hs = int'(a_val[3:0]) + int'(b[3:0]);
    @(negedge clk);
    opcode = op; imm = im; immv = iv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 12; n++) begin
      if (done) begin ndone++; dn = n; wd = a_wdata; fl = flags; end
      if (mem_re) begin nmre++; maddr = mem_addr; end
      if (illegal) begin nill++; ill_at = n; end
      @(negedge clk);
    end
    if (lat == 0) begin
      chk(nill == 1 && ill_at == 1, req, "illegal pulse", ill_at, 1);
      chk(ndone == 0, req, "done on illegal", ndone, 0);
      chk(nmre == 0, req, "mem read on illegal", nmre, 0);
    end else begin
      chk(ndone == 1, "R9", "done count", ndone, 1);
      chk(dn == lat - 1, req, "done cycle", dn, lat - 1);
      chk(nill == 0, req, "illegal on legal op", nill, 0);
      chk(wd == s[7:0], "R6", "sum", wd, s[7:0]);
      chk(fl[0] == (s > 255), "R6", "carry", fl[0], s > 255);
      chk(fl[1] == (hs > 15), "R5", "half carry", fl[1], hs > 15);
      chk(fl[2] == 1'b0, "R4", "subtract", fl[2], 0);
      chk(fl[3] == (s[7:0] == 0), "R7", "zero", fl[3], s[7:0] == 0);
      if (is_mem) begin
        chk(nmre == 1, "R2", "mem read count", nmre, 1);
        chk(maddr == mem_exp_addr, "R2", "mem address", maddr, mem_exp_addr);
      end else begin
        chk(nmre == 0, req, "unexpected mem read", nmre, 0);
      end
    end
  endtask

  task automatic reg_op(input logic [7:0] a, input logic [7:0] b, input int idx);
    for (int r = 0; r < 8; r++) regs[r] = ~b;
    regs[idx] = b;
    a_val = a;
    run_op(8'h80 + 8'(idx), 8'h00, 1'b0, 4, b, 1'b0, "R1");
  endtask

  task automatic imm_op(input logic [7:0] a, input logic [7:0] b);
    for (int r = 0; r < 8; r++) regs[r] = ~b;
    a_val = a;
    run_op(8'hC6, b, 1'b1, 4, b, 1'b0, "R3");
  endtask

  task automatic mem_op(input logic [7:0] a, input logic [7:0] b);
    for (int r = 0; r < 8; r++) regs[r] = ~b;
    regs[4] = b ^ 8'h5A;
    regs[5] = a ^ 8'hC3;
    mem_exp_addr = {regs[4], regs[5]};
    mem_val = b;
    a_val = a;
    run_op(8'h86, 8'h00, 1'b0, 8, b, 1'b1, "R2");
  endtask

  initial begin
    for (int r = 0; r < 8; r++) regs[r] = 8'h00;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && illegal == 1'b0 && mem_re == 1'b0, "R9", "reset outputs",
        {done, illegal, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && illegal == 1'b0 && flags == 4'h0, "R9", "idle after reset",
        {done, illegal, flags}, 0);

    // corner cases
    mem_op(8'h12, 8'h34);
    mem_op(8'h00, 8'h00);
    mem_op(8'h0F, 8'h01);
    mem_op(8'h80, 8'h80);
    mem_op(8'hFF, 8'h01);
    imm_op(8'h00, 8'h00);
    imm_op(8'hFF, 8'hFF);
    for (int i = 0; i < 6; i++) reg_op(8'hFF, 8'h01, i);

    // R1 sweep over registers and operand values
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 7)
        reg_op(8'(a), 8'(b), (a + b) % 6);

    // R3 sweep over immediate values
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        imm_op(8'(a), 8'(b));

    // R2 sweep over memory operands
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 11)
        mem_op(8'(a), 8'(b));

    // R8 every opcode outside the group
    a_val = 8'h77;
    for (int op = 0; op < 256; op++) begin
      if (!((op >= 8'h80 && op <= 8'h86) || op == 8'hC6))
        run_op(8'(op), 8'h11, 1'b1, 0, 8'h00, 1'b0, "R8");
    end
    // R3 immediate form without its byte
    run_op(8'hC6, 8'h11, 1'b0, 0, 8'h00, 1'b0, "R3");

    // R11 starts during a memory-indirect instruction
    begin
      int dn = 0, ndone = 0, nill = 0;
      logic [7:0] wd = 8'h00;
      for (int r = 0; r < 8; r++) regs[r] = 8'h0E;
      regs[4] = 8'hA5; regs[5] = 8'h3C;
      mem_exp_addr = 16'hA53C; mem_val = 8'h21; a_val = 8'h40;
      @(negedge clk);
      opcode = 8'h86; immv = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 1; n <= 12; n++) begin
        start = (n == 2 || n == 4);
        opcode = (n == 2) ? 8'h00 : (n == 4) ? 8'h80 : 8'h86;
        if (done) begin ndone++; dn = n; wd = a_wdata; end
        if (illegal) nill++;
        @(negedge clk);
      end
      start = 1'b0;
      chk(nill == 0, "R11", "illegal while busy", nill, 0);
      chk(ndone == 1 && dn == 7, "R11", "done cycle while busy", dn, 7);
      chk(wd == 8'h61, "R11", "result while busy", wd, 8'h61);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule